// File: doc/BRIEF.md
# Reset Input/Output Sequencer

The sequencer takes an asynchronous active-low reset request and an active-low high-impedance request from the board. It produces four things: an active-low reset output for the rest of the system, a drive enable for the three-state bus pins (including the reset output pin), a one-cycle launch pulse that lets the core begin reset exception processing, and a flag that records which kind of reset ran last. Each input passes through a two-flop synchroniser. The first flop samples on the falling clock edge and the second on the next rising edge. The reset path is also preset asynchronously, so a new reset takes hold at once and only its release is synchronised.

After the synchroniser recognises the release of reset, a counter runs. The reset output is released after a fixed stretch of clocks. The launch pulse comes at a later, separate count. If reset is applied again before the launch, the sequence returns to its start. A master reset applies both requests together. A normal reset applies only the reset request. The flag reports which of the two ran, and the drive enable keeps the bus pins floating while the high-impedance request is held.

The sequencer has five states:
- `S_HOLD`: reset is seen, and the counter is cleared.
- `S_STRETCH`: the reset output is still held while the counter runs.
- `S_SETTLE`: the reset output is released, and the counter runs on to the launch point.
- `S_LAUNCH`: the launch pulse is high for this one cycle.
- `S_RUN`: the sequencer is idle.

Its transitions are:
- any state → `S_HOLD` when reset is seen;
- `S_HOLD` → `S_STRETCH` on the first clock without reset;
- `S_STRETCH` → `S_SETTLE` when the stretch count completes;
- `S_SETTLE` → `S_LAUNCH` when the launch count completes;
- `S_LAUNCH` → `S_RUN` on the next clock.

Top module: `reset_sequencer`

## Requirements
- R1: While `rst_in_n` is low, `rst_out_n` is low from the first rising clock edge after `rst_in_n` falls. A new assertion is taken without waiting for the synchroniser.
- R2: Let E0 be the first rising edge after a falling edge that samples `rst_in_n` high. Counting E0 as edge 0, `rst_out_n` is low through edge 31 and rises at edge 32 (parameter STRETCH_CYCLES = 32).
- R3: `exc_start` is high for exactly one cycle, starting at edge 54 after E0 (parameter LAUNCH_CYCLES = 54), and it is never high at any other time.
- R4: If `rst_in_n` falls at any point before the launch pulse, `rst_out_n` is low at the next rising edge and no launch pulse is produced. After the next release, both counts start again from zero.
- R5: Each input is sampled first on a falling edge and then on the following rising edge. A change made just after a rising edge therefore shows inside the block one rising edge later.
- R6: `drive_en` is 1 exactly when the synchronised `hiz_req_n` is high (not requested), with the same latency as R5. In a master reset the bus pins therefore float until both requests are released.
- R7: `mode_master` takes the synchronised high-impedance level at every rising edge where reset is seen. It holds that value unchanged from the first edge without reset until the next reset. So it reads 1 after a master reset and 0 after a normal reset.
- R8: During a normal reset (`hiz_req_n` high), `drive_en` stays 1 so that the low `rst_out_n` is driven onto its pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_in_n | input | 1 | Asynchronous reset request, active low |
| hiz_req_n | input | 1 | Asynchronous high-impedance request, active low |
| rst_out_n | output | 1 | Stretched reset output, active low |
| drive_en | output | 1 | Enable for the three-state bus and reset-output pins |
| exc_start | output | 1 | One-cycle launch of reset exception processing |
| mode_master | output | 1 | 1 if the last reset was a master reset |

## Verification
A counter that is off by one moves the rising edge of `rst_out_n` or the launch pulse by one cycle from edge 32 or edge 54. The bench checks both outputs on every cycle of the window, so such a fault shows within the same cycle. A restart path that fails to clear the counter, or that leaves the state machine past `S_HOLD`, shows as a pulse or an early release within one count window after a re-assertion. A bad mode capture shows on `mode_master` at the first cycle after release, and a bad synchroniser shows as `drive_en` lagging its request by a cycle.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    typedef enum logic [2:0] {
        S_HOLD    = 3'd0,
        S_STRETCH = 3'd1,
        S_SETTLE  = 3'd2,
        S_LAUNCH  = 3'd3,
        S_RUN     = 3'd4
    } seq_state_e;

endpackage

// File: rtl/rstseq_sync.sv
// Falling-then-rising edge synchroniser for an active-low request.
// The output q is active high (1 = request seen).
module rstseq_sync #(
    parameter bit ASYNC_PRESET = 1'b0
) (
    input  logic clk,
    input  logic req_n,
    output logic q
);

    logic stage_fall;
    logic stage_rise;

    generate
        if (ASYNC_PRESET) begin : g_preset
            // A new request takes hold at once; only its release is timed.
            always_ff @(negedge clk or negedge req_n) begin
                if (!req_n) stage_fall <= 1'b1;
                else        stage_fall <= 1'b0;
            end
            always_ff @(posedge clk or negedge req_n) begin
                if (!req_n) stage_rise <= 1'b1;
                else        stage_rise <= stage_fall;
            end
        end else begin : g_plain
            always_ff @(negedge clk) begin
                stage_fall <= ~req_n;
            end
            always_ff @(posedge clk) begin
                stage_rise <= stage_fall;
            end
        end
    endgenerate

    assign q = stage_rise;

endmodule

// File: rtl/rstseq_fsm.sv
module rstseq_fsm
    import rstseq_pkg::*;
#(
    parameter int STRETCH_CYCLES = 32,
    parameter int LAUNCH_CYCLES  = 54
) (
    input  logic clk,
    input  logic rst_seen,
    input  logic hiz_seen,
    output logic rst_out_n,
    output logic exc_start,
    output logic mode_master
);

    localparam int CW = $clog2(LAUNCH_CYCLES + 1);
    localparam logic [CW-1:0] STRETCH_LAST = CW'(STRETCH_CYCLES - 1);
    localparam logic [CW-1:0] LAUNCH_LAST  = CW'(LAUNCH_CYCLES - 1);

    seq_state_e     state_q, state_d;
    logic [CW-1:0]  cnt_q, cnt_d;
    logic           master_q;

    // State and counter register
    always_ff @(posedge clk) begin
        state_q <= state_d;
        cnt_q   <= cnt_d;
    end

    // Mode capture: follows the high-impedance request while reset is seen
    always_ff @(posedge clk) begin
        if (rst_seen) master_q <= hiz_seen;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (rst_seen) begin
            state_d = S_HOLD;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                S_HOLD: begin
                    state_d = S_STRETCH;
                    cnt_d   = CW'(1);
                end
                S_STRETCH: begin
                    cnt_d = cnt_q + CW'(1);
                    if (cnt_q == STRETCH_LAST) state_d = S_SETTLE;
                end
                S_SETTLE: begin
                    cnt_d = cnt_q + CW'(1);
                    if (cnt_q == LAUNCH_LAST) state_d = S_LAUNCH;
                end
                S_LAUNCH: state_d = S_RUN;
                S_RUN:    state_d = S_RUN;
                default:  state_d = S_HOLD;
            endcase
        end
    end

    // Outputs
    always_comb begin
        rst_out_n   = 1'b0;
        exc_start   = 1'b0;
        mode_master = master_q;
        unique case (state_q)
            S_HOLD, S_STRETCH: rst_out_n = 1'b0;
            S_SETTLE, S_RUN:   rst_out_n = 1'b1;
            S_LAUNCH: begin
                rst_out_n = 1'b1;
                exc_start = 1'b1;
            end
            default:           rst_out_n = 1'b0;
        endcase
    end

    // Assertions
    a_r1_out_low: assert property (@(posedge clk) disable iff ($isunknown(state_q))
        rst_seen |=> !rst_out_n);
    a_r2_rise_at_stretch: assert property (@(posedge clk) disable iff ($isunknown(state_q))
        $rose(rst_out_n) |-> (cnt_q == CW'(STRETCH_CYCLES)));
    a_r3_single_pulse: assert property (@(posedge clk) disable iff ($isunknown(state_q))
        exc_start |=> !exc_start);
    a_r3_pulse_at_launch: assert property (@(posedge clk) disable iff ($isunknown(state_q))
        exc_start |-> (cnt_q == CW'(LAUNCH_CYCLES)) && rst_out_n);
    a_r4_restart: assert property (@(posedge clk) disable iff ($isunknown(state_q))
        rst_seen |=> (cnt_q == '0) && !exc_start);
    a_r7_mode_frozen: assert property (@(posedge clk) disable iff ($isunknown(state_q))
        !rst_seen |=> $stable(mode_master));

    initial begin
        a_r2_order: assert (LAUNCH_CYCLES > STRETCH_CYCLES + 1 && STRETCH_CYCLES > 1);
    end

endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer #(
    parameter int STRETCH_CYCLES = 32,
    parameter int LAUNCH_CYCLES  = 54
) (
    input  logic clk,
    input  logic rst_in_n,
    input  logic hiz_req_n,
    output logic rst_out_n,
    output logic drive_en,
    output logic exc_start,
    output logic mode_master
);

    logic rst_seen;
    logic hiz_seen;

    rstseq_sync #(.ASYNC_PRESET(1'b1)) i_sync_rst (
        .clk   (clk),
        .req_n (rst_in_n),
        .q     (rst_seen)
    );

    rstseq_sync #(.ASYNC_PRESET(1'b0)) i_sync_hiz (
        .clk   (clk),
        .req_n (hiz_req_n),
        .q     (hiz_seen)
    );

    rstseq_fsm #(
        .STRETCH_CYCLES (STRETCH_CYCLES),
        .LAUNCH_CYCLES  (LAUNCH_CYCLES)
    ) i_fsm (
        .clk         (clk),
        .rst_seen    (rst_seen),
        .hiz_seen    (hiz_seen),
        .rst_out_n   (rst_out_n),
        .exc_start   (exc_start),
        .mode_master (mode_master)
    );

    // Bus pins float while the high-impedance request is seen (R6)
    assign drive_en = ~hiz_seen;

endmodule

// File: tb/test_reset_sequencer.sv
module test_reset_sequencer;

    localparam int STR = 32;
    localparam int LAU = 54;

    logic clk = 1'b0;
    logic rst_in_n;
    logic hiz_req_n;
    logic rst_out_n;
    logic drive_en;
    logic exc_start;
    logic mode_master;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    reset_sequencer #(.STRETCH_CYCLES(STR), .LAUNCH_CYCLES(LAU)) i_reset_sequencer (
        .clk         (clk),
        .rst_in_n    (rst_in_n),
        .hiz_req_n   (hiz_req_n),
        .rst_out_n   (rst_out_n),
        .drive_en    (drive_en),
        .exc_start   (exc_start),
        .mode_master (mode_master)
    );

    function automatic logic exp_out(input int k);
        return (k >= STR);
    endfunction

    function automatic logic exp_pulse(input int k);
        return (k == LAU);
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
        end
    endtask

    // Entered at posedge+1; release, then walk the count window.
    task automatic count_run(input bit master, input int abort_k);
        bit again;
        int ab;
        again = 1'b1;
        ab    = abort_k;
        while (again) begin
            again = 1'b0;
            #1;
            rst_in_n  = 1'b1;
            hiz_req_n = 1'b1;
            @(posedge clk); #1;                     // edge E0
            chk("R2 held at E0", rst_out_n, 1'b0);
            chk("R5 hiz release one edge later", drive_en, 1'b1);
            for (int k = 1; k <= 60; k++) begin
                @(posedge clk); #1;
                chk("R2 rst_out_n", rst_out_n, exp_out(k));
                chk("R3 exc_start", exc_start, exp_pulse(k));
                if (k == 1) chk("R7 mode_master", mode_master, master);
                if (ab == k) begin
                    #1;
                    rst_in_n  = 1'b0;
                    hiz_req_n = !master;
                    @(posedge clk); #1;
                    chk("R4 out low after reassert", rst_out_n, 1'b0);
                    chk("R4 no pulse after reassert", exc_start, 1'b0);
                    repeat (2) @(posedge clk);
                    #1;
                    chk("R4 still held", rst_out_n, 1'b0);
                    ab    = 0;
                    again = 1'b1;
                    break;
                end
            end
        end
    endtask

    task automatic do_reset(input bit master, input int hold, input int abort_k);
        #1;
        rst_in_n  = 1'b0;
        hiz_req_n = !master;
        @(posedge clk); #1;
        chk("R1 out low on assert", rst_out_n, 1'b0);
        chk("R6 drive_en follows hiz", drive_en, !master);
        if (!master) chk("R8 driven in normal reset", drive_en, 1'b1);
        repeat (hold) @(posedge clk);
        #1;
        chk("R1 out low while held", rst_out_n, 1'b0);
        chk("R3 no pulse while held", exc_start, 1'b0);
        count_run(master, abort_k);
    endtask

    initial begin
        int hold;
        int ab;
        bit m;
        void'($urandom(32'h5eed_1234));
        rst_in_n  = 1'b1;
        hiz_req_n = 1'b1;
        #1 rst_in_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset state out", rst_out_n, 1'b0);
        chk("R3 reset state pulse", exc_start, 1'b0);
        chk("R8 reset state drive", drive_en, 1'b1);
        count_run(1'b0, 0);

        // Directed cases
        do_reset(1'b1, 4, 0);     // master reset
        do_reset(1'b0, 2, 0);     // normal reset
        do_reset(1'b0, 3, 31);    // restart just before release
        do_reset(1'b1, 3, 32);    // restart just after release
        do_reset(1'b0, 5, 53);    // restart just before launch
        do_reset(1'b1, 0, 1);     // restart at the first count

        // Random cases
        for (int t = 0; t < 14; t++) begin
            m    = 1'($urandom % 2);
            hold = 1 + int'($urandom % 8);
            ab   = (($urandom % 3) == 0) ? 1 + int'($urandom % 53) : 0;
            do_reset(m, hold, ab);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule